// File: doc/BRIEF.md
# Power-Up and Reset Initialization Sequencer

This block controls when a chip's outputs may drive after power-up or after an external reset request. While the sequence runs, it holds a global output-enable gate low, so every output stays tri-stated. It also holds a register-initialize strobe high so that user registers load their initial values. A counter clocked by a free-running clock sets the length of the sequence. The sequence ends at the later of two events: the counter expiring, and the configuration loader reporting that it is done.

An active-low reset request input can restart the sequence at any time. The input is first passed through a two-flop synchronizer. A low level then counts as a restart request only once it has lasted a minimum number of clock cycles, and shorter glitches are ignored. The outputs are released only when the timed sequence has finished and the request input is high. If the request input is tied high, the sequence runs by itself once power is good.

Top module: `initSequencer`

## Requirements
- R1: While `powerGood` is low, `outEnable` and `regInit` are both 0, and both go to 0 at once (asynchronously) when `powerGood` falls.
- R2: The first rising clock edge after `powerGood` rises starts initialization. With `cfgDone` already high and `rstReqN` high, `regInit` is 1 for exactly `INIT_CYC` cycles and `outEnable` is 1 from the next cycle on. `outEnable` and `regInit` are never 1 together.
- R3: Initialization does not end before `cfgDone` has been seen. A `cfgDone` pulse of a single cycle at any point during initialization is remembered. If `cfgDone` arrives after the timer has expired, initialization ends at the edge that closes the first cycle in which `cfgDone` is 1.
- R4: `rstReqN` passes through a synchronizer of `SYNC_STAGES` (2) flops. A low level sampled on `MIN_LOW_CYC` consecutive rising edges is a restart request. If the first low sample is at edge a, then at edge a+`MIN_LOW_CYC`+1 `outEnable` falls to 0 and `regInit` rises to 1.
- R5: A low level on `rstReqN` sampled on fewer than `MIN_LOW_CYC` consecutive edges has no effect, and `outEnable` stays 1.
- R6: A restart request during initialization restarts the timer, so initialization then lasts a full `INIT_CYC` cycles from the restart edge.
- R7: One continuous low period of `rstReqN` produces at most one restart, whatever its length. A low level already present when `powerGood` rises produces none.
- R8: If `rstReqN` is still low when initialization ends, both outputs are 0 until `rstReqN` goes high. If b is the first edge that samples it high, `outEnable` rises at edge b+2.
- R9: If `rstReqN` returns high before initialization ends, `outEnable` rises at the same edge that ends initialization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; also times the sequence |
| powerGood | input | 1 | Supplies valid; low acts as asynchronous reset of the block |
| rstReqN | input | 1 | Active-low asynchronous reset request |
| cfgDone | input | 1 | Configuration loader done indication (clk domain) |
| outEnable | output | 1 | Global output-enable gate; 0 keeps all outputs tri-stated |
| regInit | output | 1 | Register-initialize strobe, high during initialization |

## Verification
The bench sweeps reset-request pulse widths on both sides of the minimum and checks the exact edge at which outputs drop. A design that counted one cycle too few would restart on a glitch, and one with the wrong latency would drop `outEnable` one cycle early or late. It checks that a request arriving mid-initialization lengthens the sequence by the full count, that a long low period restarts only once, and that a level held low at power-up does not restart the sequence. A design that re-armed on a level would then loop in initialization. It also checks a late or single-cycle `cfgDone`, and release both while the request is still low and after it has already gone high. Here a design would either release early or add a spurious synchronizer delay.

// File: rtl/initSeqPkg.sv
package initSeqPkg;

  typedef enum logic [1:0] {
    ST_PWR_WAIT = 2'd0,
    ST_INIT     = 2'd1,
    ST_HOLD     = 2'd2,
    ST_RUN      = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // clear timer and loader-done latch
    logic count;    // advance timer
  } seqCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic reqHigh;    // synchronized request input is high
    logic reqQual;    // qualified restart request, one cycle
    logic timerDone;  // timed part of initialization complete
    logic cfgReady;   // loader done now or earlier in this sequence
  } seqStat_t;

endpackage

// File: rtl/initSeqDatapath.sv
module initSeqDatapath
  import initSeqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 5,
  parameter int INIT_CYC    = 8000
) (
  input  logic     clk,
  input  logic     powerGood,
  input  logic     rstReqN,
  input  logic     cfgDone,
  input  seqCtrl_t ctrl,
  output seqStat_t stat
);

  localparam int LOW_W  = $clog2(MIN_LOW_CYC + 1);
  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam logic [LOW_W-1:0]  LOW_MAX   = LOW_W'(MIN_LOW_CYC);
  localparam logic [LOW_W-1:0]  LOW_LAST  = LOW_W'(MIN_LOW_CYC - 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYC - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   reqSync;
  logic [LOW_W-1:0]       lowCnt;
  logic [INIT_W-1:0]      initCnt;
  logic                   cfgSeen;
  logic                   timerDone;

  // synchronizer chain; resets low so a level present at power-up is not an edge
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) syncQ <= '0;
    else            syncQ <= {syncQ[SYNC_STAGES-2:0], rstReqN};
  end

  assign reqSync = syncQ[SYNC_STAGES-1];

  // low-width qualifier; starts saturated so an initial low level never qualifies
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)              lowCnt <= LOW_MAX;
    else if (reqSync)            lowCnt <= '0;
    else if (lowCnt != LOW_MAX)  lowCnt <= lowCnt + LOW_W'(1);
  end

  // initialization timer, saturates at its last count
  assign timerDone = (initCnt == INIT_LAST);

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)                    initCnt <= '0;
    else if (ctrl.restart)             initCnt <= '0;
    else if (ctrl.count && !timerDone) initCnt <= initCnt + INIT_W'(1);
  end

  // loader-done latch
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)        cfgSeen <= 1'b0;
    else if (ctrl.restart) cfgSeen <= 1'b0;
    else if (cfgDone)      cfgSeen <= 1'b1;
  end

  assign stat.reqHigh   = reqSync;
  assign stat.reqQual   = !reqSync && (lowCnt == LOW_LAST);
  assign stat.timerDone = timerDone;
  assign stat.cfgReady  = cfgSeen | cfgDone;

endmodule

// File: rtl/initSeqControl.sv
module initSeqControl
  import initSeqPkg::*;
(
  input  logic     clk,
  input  logic     powerGood,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     outEnable,
  output logic     regInit
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_PWR_WAIT: stateNext = ST_INIT;
      ST_INIT: begin
        if (stat.reqQual)                          stateNext = ST_INIT;
        else if (stat.timerDone && stat.cfgReady)  stateNext = stat.reqHigh ? ST_RUN : ST_HOLD;
      end
      ST_HOLD: begin
        if (stat.reqQual)      stateNext = ST_INIT;
        else if (stat.reqHigh) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (stat.reqQual) stateNext = ST_INIT;
      end
      default: stateNext = ST_PWR_WAIT;
    endcase
  end

  assign ctrl.restart = (state == ST_PWR_WAIT) || stat.reqQual;
  assign ctrl.count   = (state == ST_INIT);

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      state     <= ST_PWR_WAIT;
      outEnable <= 1'b0;
      regInit   <= 1'b0;
    end else begin
      state     <= stateNext;
      outEnable <= (stateNext == ST_RUN);
      regInit   <= (stateNext == ST_INIT);
    end
  end

endmodule

// File: rtl/initSequencer.sv
module initSequencer
  import initSeqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 5,
  parameter int INIT_CYC    = 8000
) (
  input  logic clk,
  input  logic powerGood,
  input  logic rstReqN,
  input  logic cfgDone,
  output logic outEnable,
  output logic regInit
);

  seqCtrl_t ctrl;
  seqStat_t stat;

  initSeqDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW_CYC(MIN_LOW_CYC),
    .INIT_CYC   (INIT_CYC)
  ) uDatapath (
    .clk      (clk),
    .powerGood(powerGood),
    .rstReqN  (rstReqN),
    .cfgDone  (cfgDone),
    .ctrl     (ctrl),
    .stat     (stat)
  );

  initSeqControl uControl (
    .clk      (clk),
    .powerGood(powerGood),
    .stat     (stat),
    .ctrl     (ctrl),
    .outEnable(outEnable),
    .regInit  (regInit)
  );

endmodule

// File: rtl/initSeqChecker.sv
module initSeqChecker
  import initSeqPkg::*;
(
  input logic     clk,
  input logic     powerGood,
  input logic     outEnable,
  input logic     regInit,
  input seqStat_t stat
);

  // R2
  excl_chk: assert property (@(posedge clk) disable iff (!powerGood)
    !(outEnable && regInit));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!powerGood)
    stat.reqQual |=> (regInit && !outEnable));

  // R4
  drop_cause_chk: assert property (@(posedge clk) disable iff (!powerGood)
    $fell(outEnable) |-> $past(stat.reqQual));

  // R5
  keep_run_chk: assert property (@(posedge clk) disable iff (!powerGood)
    (outEnable && !stat.reqQual) |=> outEnable);

  // R3
  finish_cause_chk: assert property (@(posedge clk) disable iff (!powerGood)
    $fell(regInit) |-> $past(stat.timerDone && stat.cfgReady));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(outEnable) |-> $past(stat.reqHigh));

endmodule

bind initSequencer initSeqChecker uChecker (
  .clk      (clk),
  .powerGood(powerGood),
  .outEnable(outEnable),
  .regInit  (regInit),
  .stat     (stat)
);

// File: tb/initSequencer_test.sv
module initSequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 4;
  localparam int INIT_LEN   = 40;
  localparam int NUM_VEC    = 5;

  // width of low pulse, negedge index of expected drop (0 = none), expected init length
  localparam int PULSE_TAB [0:NUM_VEC-1][0:2] = '{
    '{1,           0,           0},
    '{2,           0,           0},
    '{MIN_LOW - 1, 0,           0},
    '{MIN_LOW,     MIN_LOW + 2, INIT_LEN},
    '{30,          MIN_LOW + 2, INIT_LEN}
  };

  logic clk = 1'b0;
  logic powerGood = 1'b0;
  logic rstReqN = 1'b1;
  logic cfgDone = 1'b1;
  logic outEnable, regInit;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  initSequencer #(
    .SYNC_STAGES(2),
    .MIN_LOW_CYC(MIN_LOW),
    .INIT_CYC   (INIT_LEN)
  ) uut (
    .clk      (clk),
    .powerGood(powerGood),
    .rstReqN  (rstReqN),
    .cfgDone  (cfgDone),
    .outEnable(outEnable),
    .regInit  (regInit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts negedges with regInit high until it falls; reports outEnable at that point
  task automatic measureInit(output int len, output int oeAfter);
    len = 0;
    oeAfter = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (regInit) len++;
      else if (len > 0) begin
        oeAfter = int'(outEnable);
        break;
      end
    end
  endtask

  task automatic powerCycle(input logic reqLevel, input logic cfgLevel);
    @(negedge clk);
    powerGood = 1'b0;
    #1;
    chk(outEnable == 1'b0 && regInit == 1'b0, "R1 async clear", int'(outEnable) + int'(regInit), 0);
    rstReqN = reqLevel;
    cfgDone = cfgLevel;
    repeat (2) @(negedge clk);
    powerGood = 1'b1;
  endtask

  initial begin
    int len, oe;

    // reset state
    repeat (3) @(negedge clk);
    chk(outEnable == 1'b0, "R1 oe in reset", int'(outEnable), 0);
    chk(regInit == 1'b0, "R1 init in reset", int'(regInit), 0);

    // plain power-up
    powerGood = 1'b1;
    measureInit(len, oe);
    chk(len == INIT_LEN, "R2 init length", len, INIT_LEN);
    chk(oe == 1, "R2 release", oe, 1);

    // pulse-width table
    for (int v = 0; v < NUM_VEC; v++) begin
      int width, expDrop, expLen, firstDrop, initLen;
      width = PULSE_TAB[v][0];
      expDrop = PULSE_TAB[v][1];
      expLen = PULSE_TAB[v][2];
      firstDrop = 0;
      initLen = 0;
      rstReqN = 1'b0;
      for (int t = 1; t <= width + INIT_LEN + 20; t++) begin
        @(negedge clk);
        if (!outEnable && firstDrop == 0) firstDrop = t;
        if (regInit) initLen++;
        if (t == width) rstReqN = 1'b1;
      end
      chk(firstDrop == expDrop, (expDrop == 0) ? "R5 glitch ignored" : "R4 drop edge", firstDrop, expDrop);
      chk(initLen == expLen, "R7 single restart", initLen, expLen);
      chk(outEnable == 1'b1, "R4 back in run", int'(outEnable), 1);
    end

    // late loader done
    powerCycle(1'b1, 1'b0);
    len = 0;
    oe = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (regInit) begin
        len++;
        if (len == INIT_LEN + 7) cfgDone = 1'b1;
      end else if (len > 0) begin
        oe = int'(outEnable);
        break;
      end
    end
    chk(len == INIT_LEN + 7, "R3 late done", len, INIT_LEN + 7);
    chk(oe == 1, "R3 release after done", oe, 1);

    // single-cycle loader done pulse early in init
    powerCycle(1'b1, 1'b0);
    len = 0;
    oe = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (regInit) begin
        len++;
        if (len == 3) cfgDone = 1'b1;
        if (len == 4) cfgDone = 1'b0;
      end else if (len > 0) begin
        oe = int'(outEnable);
        break;
      end
    end
    chk(len == INIT_LEN, "R3 pulse remembered", len, INIT_LEN);
    chk(oe == 1, "R3 pulse release", oe, 1);
    cfgDone = 1'b1;

    // restart request during init
    powerCycle(1'b1, 1'b1);
    len = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (regInit) begin
        len++;
        if (len == 5) rstReqN = 1'b0;
        if (len == 5 + MIN_LOW) rstReqN = 1'b1;
      end else if (len > 0) break;
    end
    chk(len == INIT_LEN + 5 + MIN_LOW + 1, "R6 timer restarted", len, INIT_LEN + 5 + MIN_LOW + 1);

    // request held low past end of init
    @(negedge clk);
    rstReqN = 1'b0;
    measureInit(len, oe);
    chk(len == INIT_LEN, "R8 init length", len, INIT_LEN);
    chk(oe == 0, "R8 held off", oe, 1'b0);
    repeat (5) @(negedge clk);
    chk(outEnable == 1'b0 && regInit == 1'b0, "R8 waiting", int'(outEnable) + int'(regInit), 0);
    rstReqN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(outEnable == 1'b0, "R8 sync latency", int'(outEnable), 0);
    @(negedge clk);
    chk(outEnable == 1'b1, "R8 release edge", int'(outEnable), 1);

    // request released before init ends
    rstReqN = 1'b0;
    repeat (MIN_LOW + 10) @(negedge clk);
    rstReqN = 1'b1;
    measureInit(len, oe);
    chk(oe == 1, "R9 release at init end", oe, 1);

    // request low at power-up
    powerCycle(1'b0, 1'b1);
    measureInit(len, oe);
    chk(len == INIT_LEN, "R7 no restart at power-up", len, INIT_LEN);
    chk(oe == 0, "R7 waits for request high", oe, 0);
    rstReqN = 1'b1;
    repeat (3) @(negedge clk);
    chk(outEnable == 1'b1, "R8 release after power-up", int'(outEnable), 1);

    // power loss while running
    powerGood = 1'b0;
    #1;
    chk(outEnable == 1'b0 && regInit == 1'b0, "R1 power loss", int'(outEnable) + int'(regInit), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule